// File: doc/BRIEF.md
# Serial Port Clock Generator

This block produces the bit-rate timing for a serial port that works either as an asynchronous UART or as a clock-synchronous shift interface. It runs in the system clock domain only. It emits its bit clocks as one-cycle enable strobes, `tx_en_o` and `rx_en_o`, which the shift logic next to it uses. It does not emit derived clocks.

The rate is set in three stages. A free-running prescaler offers three taps: the system clock (optionally halved), the system clock divided by 8, and that result divided by a further 4. The selected tap feeds a reload down-counter that divides by (n+1). A last stage then divides by 16 for UART operation or by 2 to form the serial clock pin in synchronous master mode. In synchronous slave mode the external clock pin is synchronized, and its edges produce the strobes. A handshake pin can be turned off, used as a clear-to-send input, or used as a request-to-send output.

All settings are written together through a single parallel load strobe.

Top module: `sclk_gen`

## Requirements
- R1: After reset, both strobes are 0, `sclk_o` is 1, `sclk_oe_o` is 0, `hs_oe_o` is 0 and `tx_permit_o` is 1. In the reset configuration the mode code is 000 and the handshake is off.
- R2: Source select 00 feeds the reload counter once per system clock when `cfg_half_i`=0, and once every 2 system clocks when `cfg_half_i`=1.
- R3: Source select 01 feeds it once every 8 system clocks. Source select 10 (and 11) feeds it once every 32.
- R4: The reload counter gives one tick per (n+1) source ticks, where n is the 8-bit `cfg_reload_i` value (0 to 255).
- R5: Mode codes 010, 100, 101 and 110 are UART modes. In these modes `tx_en_o` and `rx_en_o` pulse together once per 16 reload ticks, `sclk_oe_o` is 0 and `cfg_ext_clk_i` has no effect.
- R6: Mode 001 with `cfg_ext_clk_i`=0 is synchronous master mode. Here `sclk_oe_o` is 1 and `sclk_o` toggles on each reload tick, idling high. `tx_en_o` pulses in the cycle the uninverted clock falls, and `rx_en_o` pulses in the cycle it rises. The two never pulse together.
- R7: With `cfg_clk_inv_i`=1, the level on `sclk_o` is inverted. In slave mode the roles of the external pin edges are swapped: tx follows a rising pin edge and rx follows a falling one.
- R8: Mode 001 with `cfg_ext_clk_i`=1 is slave mode. `sclk_oe_o` is 0. A falling (uninverted) edge on `ext_clk_i` driven between two rising clock edges gives a `tx_en_o` pulse visible after the third following rising clock edge. A rising edge gives `rx_en_o` with the same delay.
- R9: Mode codes 000, 011 and 111 produce no strobes, drive `sclk_oe_o` to 0 and hold all divider counters at zero.
- R10: A new reload value written while running only takes effect at the next terminal count. The interval in progress completes with the old value, so no shortened pulse appears.
- R11: With `cfg_hs_off_i`=1, `hs_oe_o` is 0 and `tx_permit_o` is 1. In RTS role (`cfg_hs_rts_i`=1), `hs_oe_o` is 1 and `hs_pin_o` equals NOT `rx_ready_i`. In CTS role, `hs_oe_o` is 0 and `tx_permit_o` equals NOT `hs_pin_i`.
- R12: Every strobe is exactly one system clock wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_load_i | input | 1 | Loads all cfg_* fields on this clock edge |
| cfg_src_sel_i | input | 2 | Prescaler tap select |
| cfg_half_i | input | 1 | First tap is system clock halved |
| cfg_reload_i | input | 8 | Reload value n, divide by n+1 |
| cfg_mode_i | input | 3 | Operating mode code |
| cfg_ext_clk_i | input | 1 | Synchronous mode uses the external clock pin |
| cfg_clk_inv_i | input | 1 | Serial clock polarity inversion |
| cfg_hs_off_i | input | 1 | Handshake pin unused |
| cfg_hs_rts_i | input | 1 | Handshake pin is RTS output (else CTS input) |
| ext_clk_i | input | 1 | External serial clock pin |
| hs_pin_i | input | 1 | Handshake pin input level (CTS, active low) |
| rx_ready_i | input | 1 | Receiver can accept data |
| tx_en_o | output | 1 | Transmit bit strobe |
| rx_en_o | output | 1 | Receive bit strobe |
| sclk_o | output | 1 | Serial clock pin level |
| sclk_oe_o | output | 1 | Serial clock pin output enable |
| hs_pin_o | output | 1 | Handshake pin output level (RTS, active low) |
| hs_oe_o | output | 1 | Handshake pin output enable |
| tx_permit_o | output | 1 | Transmission allowed by handshake |

## Verification
Two things can land in the same cycle here.

The first is the transmit and receive strobes. In UART modes they must coincide, and in synchronous modes they must never do so. Each period vector checks the receive strobe in the exact cycle the transmit strobe is seen: set in UART rows, clear in synchronous rows.

The second is a reload write and a running countdown. The bench writes a new divisor one cycle after a clock toggle. It then requires the next toggle interval to still use the old divisor and the one after to use the new divisor.

// File: rtl/sclk_pkg.sv
package sclk_pkg;

  typedef enum logic [1:0] {
    OP_OFF      = 2'd0,
    OP_UART     = 2'd1,
    OP_SYNC_INT = 2'd2,
    OP_SYNC_EXT = 2'd3
  } op_e;

  typedef struct packed {
    logic [1:0] src_sel;
    logic       half;
    logic [2:0] mode;
    logic       ext_clk;
    logic       clk_inv;
    logic       hs_off;
    logic       hs_rts;
  } ctrl_t;

  function automatic op_e decode_op(input logic [2:0] mode, input logic ext_clk);
    op_e op;
    case (mode)
      3'b001:                         op = ext_clk ? OP_SYNC_EXT : OP_SYNC_INT;
      3'b010, 3'b100, 3'b101, 3'b110: op = OP_UART;
      default:                        op = OP_OFF;
    endcase
    return op;
  endfunction

endpackage

// File: rtl/sclk_prescale.sv
module sclk_prescale #(
  parameter int TAP_A = 8,
  parameter int TAP_B = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic [1:0] sel_i,
  input  logic       half_i,
  output logic       tick_o
);
  localparam int CW = $clog2(TAP_A * TAP_B);
  localparam int AW = $clog2(TAP_A);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          tick_first, tick_a, tick_b, tick_sel;

  always_comb begin
    cnt_d = run_i ? cnt_q + CW'(1) : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  always_comb begin
    tick_first = half_i ? cnt_q[0] : 1'b1;
    tick_a     = &cnt_q[AW-1:0];
    tick_b     = &cnt_q;
    case (sel_i)
      2'b00:   tick_sel = tick_first;
      2'b01:   tick_sel = tick_a;
      default: tick_sel = tick_b;
    endcase
    tick_o = run_i & tick_sel;
  end

  // R2: halved first tap never fires on two adjacent cycles
  a_r2_half_alternates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && sel_i == 2'b00 && half_i) |=> !(tick_o && sel_i == 2'b00 && half_i));

endmodule

// File: rtl/sclk_reload_div.sv
module sclk_reload_div #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         src_tick_i,
  input  logic [W-1:0] reload_i,
  output logic         tick_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         terminal;

  always_comb begin
    terminal = (cnt_q == '0);
    tick_o   = run_i & src_tick_i & terminal;
    if (!run_i)          cnt_d = '0;
    else if (!src_tick_i) cnt_d = cnt_q;
    else if (terminal)    cnt_d = reload_i;
    else                  cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  // R4: a mid-count source tick steps the counter down by one
  a_r4_step_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && src_tick_i && cnt_q != '0) |=> (!run_i || cnt_q == $past(cnt_q) - W'(1)));

  // R9: stopping returns the counter to zero
  a_r9_stop_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0));

endmodule

// File: rtl/sclk_final.sv
module sclk_final
  import sclk_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  op_e  op_i,
  input  logic brg_tick_i,
  input  logic ext_clk_i,
  input  logic clk_inv_i,
  output logic tx_en_o,
  output logic rx_en_o,
  output logic sclk_o,
  output logic sclk_oe_o
);
  localparam int OW = $clog2(OVS);

  logic [OW-1:0] ovs_q, ovs_d;
  logic          ph_q, ph_d;
  logic          s1_q, s2_q, prev_q, lvl;
  logic          tx_q, tx_d, rx_q, rx_d;
  logic          bit_tick, fall, rise;

  always_comb begin
    bit_tick = brg_tick_i && (ovs_q == OW'(OVS - 1));
    lvl      = s2_q ^ clk_inv_i;
    fall     = prev_q & ~lvl;
    rise     = ~prev_q & lvl;

    ovs_d = '0;
    ph_d  = 1'b1;
    tx_d  = 1'b0;
    rx_d  = 1'b0;
    case (op_i)
      OP_UART: begin
        if (brg_tick_i) ovs_d = bit_tick ? '0 : ovs_q + OW'(1);
        else            ovs_d = ovs_q;
        tx_d = bit_tick;
        rx_d = bit_tick;
      end
      OP_SYNC_INT: begin
        ph_d = brg_tick_i ? ~ph_q : ph_q;
        tx_d = brg_tick_i & ph_q;
        rx_d = brg_tick_i & ~ph_q;
      end
      OP_SYNC_EXT: begin
        tx_d = fall;
        rx_d = rise;
      end
      default: begin
        tx_d = 1'b0;
        rx_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovs_q  <= '0;
      ph_q   <= 1'b1;
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      prev_q <= 1'b1;
      tx_q   <= 1'b0;
      rx_q   <= 1'b0;
    end else begin
      ovs_q  <= ovs_d;
      ph_q   <= ph_d;
      s1_q   <= ext_clk_i;
      s2_q   <= s1_q;
      prev_q <= lvl;
      tx_q   <= tx_d;
      rx_q   <= rx_d;
    end
  end

  assign tx_en_o   = tx_q;
  assign rx_en_o   = rx_q;
  assign sclk_o    = ph_q ^ clk_inv_i;
  assign sclk_oe_o = (op_i == OP_SYNC_INT);

  // R5: UART strobes come as a pair
  a_r5_uart_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(op_i) == OP_UART) |-> (tx_q == rx_q));

  // R6: synchronous strobes never coincide
  a_r6_sync_apart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(op_i) == OP_SYNC_INT || $past(op_i) == OP_SYNC_EXT) |-> !(tx_q && rx_q));

  // R6: the master clock only moves together with a strobe
  a_r6_clk_with_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(op_i) == OP_SYNC_INT && ph_q != $past(ph_q)) |-> (tx_q || rx_q));

  // R12: a strobe lasts one cycle
  a_r12_tx_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_q && $past(op_i) == op_i) |=> (!tx_q || op_i != $past(op_i)));

endmodule

// File: rtl/sclk_gen.sv
module sclk_gen
  import sclk_pkg::*;
#(
  parameter int RELOAD_W = 8,
  parameter int TAP_A    = 8,
  parameter int TAP_B    = 4,
  parameter int OVS      = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_load_i,
  input  logic [1:0]          cfg_src_sel_i,
  input  logic                cfg_half_i,
  input  logic [RELOAD_W-1:0] cfg_reload_i,
  input  logic [2:0]          cfg_mode_i,
  input  logic                cfg_ext_clk_i,
  input  logic                cfg_clk_inv_i,
  input  logic                cfg_hs_off_i,
  input  logic                cfg_hs_rts_i,
  input  logic                ext_clk_i,
  input  logic                hs_pin_i,
  input  logic                rx_ready_i,
  output logic                tx_en_o,
  output logic                rx_en_o,
  output logic                sclk_o,
  output logic                sclk_oe_o,
  output logic                hs_pin_o,
  output logic                hs_oe_o,
  output logic                tx_permit_o
);
  ctrl_t               ctrl_q, ctrl_d;
  logic [RELOAD_W-1:0] reload_q, reload_d;
  op_e                 op;
  logic                run_int, src_tick, brg_tick;

  always_comb begin
    ctrl_d   = ctrl_q;
    reload_d = reload_q;
    if (cfg_load_i) begin
      ctrl_d.src_sel = cfg_src_sel_i;
      ctrl_d.half    = cfg_half_i;
      ctrl_d.mode    = cfg_mode_i;
      ctrl_d.ext_clk = cfg_ext_clk_i;
      ctrl_d.clk_inv = cfg_clk_inv_i;
      ctrl_d.hs_off  = cfg_hs_off_i;
      ctrl_d.hs_rts  = cfg_hs_rts_i;
      reload_d       = cfg_reload_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '{src_sel: 2'b00, half: 1'b0, mode: 3'b000, ext_clk: 1'b0,
                    clk_inv: 1'b0, hs_off: 1'b1, hs_rts: 1'b0};
      reload_q <= '0;
    end else begin
      ctrl_q   <= ctrl_d;
      reload_q <= reload_d;
    end
  end

  always_comb begin
    op      = decode_op(ctrl_q.mode, ctrl_q.ext_clk);
    run_int = (op == OP_UART) || (op == OP_SYNC_INT);
  end

  sclk_prescale #(.TAP_A(TAP_A), .TAP_B(TAP_B)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_int),
    .sel_i  (ctrl_q.src_sel),
    .half_i (ctrl_q.half),
    .tick_o (src_tick)
  );

  sclk_reload_div #(.W(RELOAD_W)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run_int),
    .src_tick_i (src_tick),
    .reload_i   (reload_q),
    .tick_o     (brg_tick)
  );

  sclk_final #(.OVS(OVS)) u_fin (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .op_i       (op),
    .brg_tick_i (brg_tick),
    .ext_clk_i  (ext_clk_i),
    .clk_inv_i  (ctrl_q.clk_inv),
    .tx_en_o    (tx_en_o),
    .rx_en_o    (rx_en_o),
    .sclk_o     (sclk_o),
    .sclk_oe_o  (sclk_oe_o)
  );

  // Handshake pin role
  always_comb begin
    hs_oe_o     = !ctrl_q.hs_off && ctrl_q.hs_rts;
    hs_pin_o    = hs_oe_o ? !rx_ready_i : 1'b1;
    tx_permit_o = (ctrl_q.hs_off || ctrl_q.hs_rts) ? 1'b1 : !hs_pin_i;
  end

  // R11: handshake off leaves the pin undriven and transmission free
  a_r11_hs_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q.hs_off |-> (!hs_oe_o && tx_permit_o));

  // R11: a driven pin carries the inverted ready level
  a_r11_rts_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs_oe_o |-> (hs_pin_o == !rx_ready_i));

  // R9: idle modes stay silent
  a_r9_off_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_OFF) |=> (!tx_en_o && !rx_en_o));

  // R8: slave mode never drives the clock pin
  a_r8_slave_undriven: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_SYNC_EXT) |-> !sclk_oe_o);

endmodule

// File: tb/tb_sclk_gen.sv
module tb_sclk_gen;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_load = 1'b0;
  logic [1:0] cfg_sel = 2'b00;
  logic       cfg_half = 1'b0;
  logic [7:0] cfg_n = 8'd0;
  logic [2:0] cfg_mode = 3'b000;
  logic       cfg_ext = 1'b0;
  logic       cfg_inv = 1'b0;
  logic       cfg_hs_off = 1'b1;
  logic       cfg_hs_rts = 1'b0;
  logic       ext_clk = 1'b1;
  logic       hs_pin = 1'b1;
  logic       rx_ready = 1'b0;
  logic       tx_en, rx_en, sclk, sclk_oe, hs_out, hs_oe, permit;

  int errs = 0;
  int checks = 0;
  int cyc = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sclk_gen dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_load_i(cfg_load), .cfg_src_sel_i(cfg_sel),
    .cfg_half_i(cfg_half), .cfg_reload_i(cfg_n), .cfg_mode_i(cfg_mode),
    .cfg_ext_clk_i(cfg_ext), .cfg_clk_inv_i(cfg_inv), .cfg_hs_off_i(cfg_hs_off),
    .cfg_hs_rts_i(cfg_hs_rts), .ext_clk_i(ext_clk), .hs_pin_i(hs_pin),
    .rx_ready_i(rx_ready), .tx_en_o(tx_en), .rx_en_o(rx_en), .sclk_o(sclk),
    .sclk_oe_o(sclk_oe), .hs_pin_o(hs_out), .hs_oe_o(hs_oe), .tx_permit_o(permit)
  );

  // mode, ext, sel, half, n, expected tx period, uart flag
  localparam int NV = 9;
  localparam int VEC [NV][7] = '{
    '{2, 0, 0, 0,   0,   16, 1},  // R5 R4 f1
    '{4, 0, 0, 1,   2,   96, 1},  // R2 halved tap
    '{5, 0, 1, 0,   1,  256, 1},  // R3 div-8 tap
    '{6, 0, 2, 0,   0,  512, 1},  // R3 div-32 tap
    '{2, 0, 0, 0, 255, 4096, 1},  // R4 largest reload
    '{1, 0, 0, 0,   0,    2, 0},  // R6 fastest master clock
    '{1, 0, 0, 0,   4,   10, 0},  // R6
    '{1, 0, 1, 0,   2,   48, 0},  // R6 R3
    '{2, 1, 0, 0,   1,   32, 1}   // R5 external select ignored
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load(input int mode, input int ext, input int sel, input int half,
                      input int n, input int inv, input int hoff, input int hrts);
    cfg_mode = 3'(mode); cfg_ext = 1'(ext); cfg_sel = 2'(sel); cfg_half = 1'(half);
    cfg_n = 8'(n); cfg_inv = 1'(inv); cfg_hs_off = 1'(hoff); cfg_hs_rts = 1'(hrts);
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic wait_tx(output int at);
    int n = 0;
    while (!tx_en && n < 20000) begin
      @(negedge clk);
      n++;
    end
    at = cyc;
    if (n >= 20000) check("R12 tx strobe timeout", 0, 1);
  endtask

  task automatic wait_edge(output int at);
    logic l = sclk;
    int n = 0;
    while (sclk == l && n < 20000) begin
      @(negedge clk);
      n++;
    end
    at = cyc;
    if (n >= 20000) check("R10 clock edge timeout", 0, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int t0, t1, t2, k, cnt;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 tx_en", tx_en, 0);
    check("R1 rx_en", rx_en, 0);
    check("R1 sclk", sclk, 1);
    check("R1 sclk_oe", sclk_oe, 0);
    check("R1 hs_oe", hs_oe, 0);
    check("R1 permit", permit, 1);

    // Period table
    for (int i = 0; i < NV; i++) begin
      load(0, 0, 0, 0, 0, 0, 1, 0);
      load(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4], 0, 1, 0);
      wait_tx(t0);
      @(negedge clk);
      wait_tx(t1);
      check($sformatf("R4 period row %0d", i), t1 - t0, VEC[i][5]);
      if (VEC[i][6] == 1) begin
        check($sformatf("R5 rx with tx row %0d", i), rx_en, 1);
        check($sformatf("R5 oe row %0d", i), sclk_oe, 0);
      end else begin
        check($sformatf("R6 rx apart row %0d", i), rx_en, 0);
        check($sformatf("R6 clk low after tx row %0d", i), sclk, 0);
        check($sformatf("R6 oe row %0d", i), sclk_oe, 1);
      end
      @(negedge clk);
      check($sformatf("R12 one cycle row %0d", i), tx_en, 0);
    end

    // R9 unused mode codes stay silent
    foreach (VEC[j]) begin end
    for (int m = 0; m < 3; m++) begin
      int code = (m == 0) ? 0 : (m == 1) ? 3 : 7;
      load(code, 0, 0, 0, 0, 0, 1, 0);
      cnt = 0;
      for (int c = 0; c < 100; c++) begin
        if (tx_en || rx_en) cnt++;
        @(negedge clk);
      end
      check($sformatf("R9 strobes code %0d", code), cnt, 0);
      check($sformatf("R9 oe code %0d", code), sclk_oe, 0);
    end

    // R7 inverted master clock
    load(1, 0, 0, 0, 4, 1, 1, 0);
    wait_tx(t0);
    check("R7 inverted level after tx", sclk, 1);

    // R10 reload change completes current interval
    load(0, 0, 0, 0, 0, 0, 1, 0);
    load(1, 0, 0, 0, 9, 0, 1, 0);
    wait_edge(t0);
    load(1, 0, 0, 0, 4, 0, 1, 0);
    wait_edge(t1);
    wait_edge(t2);
    check("R10 old interval", t1 - t0, 10);
    check("R10 new interval", t2 - t1, 5);

    // R8 slave mode, uninverted
    load(0, 0, 0, 0, 0, 0, 1, 0);
    ext_clk = 1'b1;
    load(1, 1, 0, 0, 0, 0, 1, 0);
    repeat (4) @(negedge clk);
    check("R8 oe", sclk_oe, 0);
    ext_clk = 1'b0;
    k = 0;
    while (!tx_en && k < 10) begin @(negedge clk); k++; end
    check("R8 tx delay", k, 3);
    check("R8 rx quiet on fall", rx_en, 0);
    @(negedge clk);
    check("R12 slave tx width", tx_en, 0);
    ext_clk = 1'b1;
    k = 0;
    while (!rx_en && k < 10) begin @(negedge clk); k++; end
    check("R8 rx delay", k, 3);

    // R7 slave mode, inverted: pin fall becomes receive edge
    load(1, 1, 0, 0, 0, 1, 1, 0);
    repeat (4) @(negedge clk);
    ext_clk = 1'b0;
    k = 0;
    while (!rx_en && k < 10) begin @(negedge clk); k++; end
    check("R7 inverted fall gives rx", k, 3);
    ext_clk = 1'b1;
    k = 0;
    while (!tx_en && k < 10) begin @(negedge clk); k++; end
    check("R7 inverted rise gives tx", k, 3);

    // R11 handshake roles
    load(0, 0, 0, 0, 0, 0, 1, 0);
    hs_pin = 1'b1;
    #1;
    check("R11 off oe", hs_oe, 0);
    check("R11 off permit", permit, 1);
    load(0, 0, 0, 0, 0, 0, 0, 1);
    rx_ready = 1'b1;
    #1;
    check("R11 rts oe", hs_oe, 1);
    check("R11 rts ready", hs_out, 0);
    rx_ready = 1'b0;
    #1;
    check("R11 rts busy", hs_out, 1);
    load(0, 0, 0, 0, 0, 0, 0, 0);
    hs_pin = 1'b0;
    #1;
    check("R11 cts oe", hs_oe, 0);
    check("R11 cts low", permit, 1);
    hs_pin = 1'b1;
    #1;
    check("R11 cts high", permit, 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule